// File: doc/BRIEF.md
# Multithreaded Pipeline Stage Controller

This block keeps the control state of one stage in an in-order pipeline that runs several hardware threads. Every cycle it looks at the block, unblock and squash strobes coming back from later stages and at the stall requests raised by local resources. From these it moves each thread through a small status machine, sends one-cycle block and unblock pulses toward the previous stage, flags per-thread activity, and reports whether the stage has internal work to do because some thread is draining its skid buffer.

The stage's position in the pipeline is a parameter. So is the furthest later stage whose stall requests are tracked. Stall requests from later stages are sticky: they hold until an explicit release. Resource stalls are kept in a small table for each thread. Each table entry is identified by a resource number, an instruction tag and a slot, and it is released only by a clear that names all three. The instruction datapath itself sits outside this block. The only thing it tells the controller is whether each thread's skid buffer is empty.

Top module: `stage_thread_ctrl`

## Requirements
- R1: After reset every thread reads Idle on `threadState`, all pulse outputs and `stageActive` are low, and `squashSeqOut` is zero. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4.
- R2: For each thread there is a sticky stall bit for each stage index s with STAGE_IDX < s <= LAST_STALL. A block strobe sets the bit and an unblock strobe clears it. If both arrive in the same cycle, the bit ends up cleared.
- R3: Block, unblock and squash strobes on stage indices below STAGE_IDX have no effect. A block from a tracked stage other than STAGE_IDX+1 does not stall the thread.
- R4: A squash for a thread from any stage index >= STAGE_IDX loads `squashSeqOut` with the sequence number from the lowest such index. Without a stall, the thread then goes to Unblocking if its skid buffer is not empty and to Running if it is, with no block or unblock pulse. Squashing is never held across a clock edge.
- R5: A thread is stalled when the stall bit of STAGE_IDX+1 is set or when it has any pending resource stall. A stalled thread that is not already Blocked becomes Blocked and pulses `blockOut`. It also pulses `activityOut`, unless it was Unblocking and saw no squash in that cycle. A thread that is already Blocked stays Blocked and gives no pulse.
- R6: When an unstalled Blocked thread has an empty skid buffer, it moves to Running and pulses both `unblockOut` and `activityOut`. If the skid buffer is not empty, it moves to Unblocking with no pulse.
- R7: An unstalled Unblocking thread moves to Running, with `unblockOut` and `activityOut` pulses, once its skid buffer is empty. Until then it stays Unblocking. An unstalled Idle or Running thread keeps its state.
- R8: A resource-stall set adds one entry to the named thread. A clear removes exactly one pending entry of that thread, and only if the thread, resource, tag and slot all match. A clear that does not match changes nothing, and duplicate entries each need their own clear.
- R9: Each thread holds RES_DEPTH resource entries. A set that arrives while the thread's table is full is dropped.
- R10: `stageActive` is high while any thread is Unblocking. `activateEvt` pulses for one cycle when it rises, and `deactivateEvt` pulses for one cycle when it falls.
- R11: With STAGE_IDX=0 there is no previous stage: `blockOut` and `unblockOut` stay low while thread states still change as usual.
- R12: All outputs are registered and update on the clock edge that samples the causing inputs. A resource set or clear takes part in the stall decision of its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blockIn | input | NUM_STAGES*NUM_THREADS | Block strobe per [stage][thread] |
| unblockIn | input | NUM_STAGES*NUM_THREADS | Unblock strobe per [stage][thread] |
| squashIn | input | NUM_STAGES*NUM_THREADS | Squash strobe per [stage][thread] |
| squashSeqIn | input | NUM_STAGES*NUM_THREADS*SEQ_W | Squash sequence number per [stage][thread] |
| skidEmpty | input | NUM_THREADS | Skid buffer of the thread is empty |
| resSetValid | input | 1 | Add a resource stall entry |
| resSetThread | input | THR_W | Thread of the added entry |
| resSetId | input | RES_ID_W | Resource number of the added entry |
| resSetTag | input | TAG_W | Instruction tag of the added entry |
| resSetSlot | input | SLOT_W | Slot of the added entry |
| resClrValid | input | 1 | Remove one matching resource stall entry |
| resClrThread | input | THR_W | Thread of the clear |
| resClrId | input | RES_ID_W | Resource number to match |
| resClrTag | input | TAG_W | Instruction tag to match |
| resClrSlot | input | SLOT_W | Slot to match |
| threadState | output | NUM_THREADS*3 | Registered state code per thread |
| blockOut | output | NUM_THREADS | One-cycle block pulse to the previous stage |
| unblockOut | output | NUM_THREADS | One-cycle unblock pulse to the previous stage |
| activityOut | output | NUM_THREADS | One-cycle activity flag per thread |
| squashSeqOut | output | NUM_THREADS*SEQ_W | Last captured squash sequence number |
| stageActive | output | 1 | Some thread is Unblocking |
| activateEvt | output | 1 | Pulse when stageActive rises |
| deactivateEvt | output | 1 | Pulse when stageActive falls |

## Verification
Every result of this block, including the state code, the block, unblock and activity pulses, the captured squash number and the stage activity events, is due exactly one clock edge after the inputs that cause it. The bench drives a stimulus a few nanoseconds after a rising edge and reads the outputs 2 ns after the next rising edge. It clears its strobes right after that read, so every pulse is seen in exactly the cycle it belongs to. A single-pulse check is followed by an idle cycle wherever stickiness or the absence of a repeated pulse matters. In the sweep, each starting state is first reached through the block's own inputs, and then one cycle of stimulus is applied and checked against an arithmetic model of the requirements.

// File: rtl/stc_pkg.sv
package stc_pkg;

  // Per-thread status codes; numeric values are visible on threadState.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_UNBLK  = 3'd3,
    ST_SQUASH = 3'd4
  } thrState_e;

  // Strobes handed from the signal path to the thread control, per thread.
  typedef struct packed {
    logic stalled;
    logic squash;
  } thrEvt_t;

endpackage

// File: rtl/stc_signal_path.sv
module stc_signal_path
  import stc_pkg::*;
#(
  parameter int NUM_STAGES  = 4,
  parameter int NUM_THREADS = 2,
  parameter int STAGE_IDX   = 1,
  parameter int LAST_STALL  = NUM_STAGES - 1,
  parameter int SEQ_W       = 8,
  parameter int RES_ID_W    = 3,
  parameter int TAG_W       = 6,
  parameter int SLOT_W      = 2,
  parameter int RES_DEPTH   = 4,
  localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                                             clk,
  input  logic                                             rstN,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0]           blockIn,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0]           unblockIn,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0]           squashIn,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0][SEQ_W-1:0] squashSeqIn,
  input  logic                                             resSetValid,
  input  logic [THR_W-1:0]                                 resSetThread,
  input  logic [RES_ID_W-1:0]                              resSetId,
  input  logic [TAG_W-1:0]                                 resSetTag,
  input  logic [SLOT_W-1:0]                                resSetSlot,
  input  logic                                             resClrValid,
  input  logic [THR_W-1:0]                                 resClrThread,
  input  logic [RES_ID_W-1:0]                              resClrId,
  input  logic [TAG_W-1:0]                                 resClrTag,
  input  logic [SLOT_W-1:0]                                resClrSlot,
  output thrEvt_t                                          evt [NUM_THREADS],
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]                squashSeqOut
);

  localparam bit HAS_NEXT = (STAGE_IDX < NUM_STAGES - 1);

  function automatic logic [NUM_STAGES-1:0] trackMask();
    logic [NUM_STAGES-1:0] m;
    for (int s = 0; s < NUM_STAGES; s++) m[s] = (s > STAGE_IDX) && (s <= LAST_STALL);
    return m;
  endfunction

  localparam logic [NUM_STAGES-1:0] TRACK = trackMask();

  // ---------------- sticky stall bits per later stage ----------------
  logic [NUM_STAGES-1:0][NUM_THREADS-1:0] stallBits, stallNext;
  logic [NUM_THREADS-1:0] nxtStall;

  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      stallNext[s] = ((stallBits[s] | blockIn[s]) & ~unblockIn[s]) & {NUM_THREADS{TRACK[s]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stallBits <= '0;
    else       stallBits <= stallNext;
  end

  generate
    if (HAS_NEXT) begin : g_next
      assign nxtStall = stallNext[STAGE_IDX+1];
    end else begin : g_last
      assign nxtStall = '0;
    end
  endgenerate

  // ---------------- squash selection, lowest stage wins ----------------
  logic [NUM_THREADS-1:0]            squashAny;
  logic [NUM_THREADS-1:0][SEQ_W-1:0] pickSeq;

  always_comb begin
    squashAny = '0;
    pickSeq   = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      for (int s = NUM_STAGES - 1; s >= 0; s--) begin
        if (s >= STAGE_IDX && squashIn[s][t]) begin
          squashAny[t] = 1'b1;
          pickSeq[t]   = squashSeqIn[s][t];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) squashSeqOut <= '0;
    else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (squashAny[t]) squashSeqOut[t] <= pickSeq[t];
      end
    end
  end

  // ---------------- resource stall table per thread ----------------
  logic [NUM_THREADS-1:0][RES_DEPTH-1:0] rv, rvN;
  logic [RES_ID_W-1:0] rId   [NUM_THREADS][RES_DEPTH];
  logic [RES_ID_W-1:0] rIdN  [NUM_THREADS][RES_DEPTH];
  logic [TAG_W-1:0]    rTag  [NUM_THREADS][RES_DEPTH];
  logic [TAG_W-1:0]    rTagN [NUM_THREADS][RES_DEPTH];
  logic [SLOT_W-1:0]   rSlot [NUM_THREADS][RES_DEPTH];
  logic [SLOT_W-1:0]   rSlotN[NUM_THREADS][RES_DEPTH];
  logic [NUM_THREADS-1:0] resPend;

  always_comb begin
    logic hit;
    logic placed;
    rvN    = rv;
    rIdN   = rId;
    rTagN  = rTag;
    rSlotN = rSlot;
    for (int t = 0; t < NUM_THREADS; t++) begin
      hit = 1'b0;
      if (resClrValid && resClrThread == THR_W'(t)) begin
        for (int d = 0; d < RES_DEPTH; d++) begin
          if (!hit && rv[t][d] && rId[t][d] == resClrId &&
              rTag[t][d] == resClrTag && rSlot[t][d] == resClrSlot) begin
            rvN[t][d] = 1'b0;
            hit = 1'b1;
          end
        end
      end
      placed = 1'b0;
      if (resSetValid && resSetThread == THR_W'(t)) begin
        for (int d = 0; d < RES_DEPTH; d++) begin
          if (!placed && !rv[t][d]) begin
            rvN[t][d]    = 1'b1;
            rIdN[t][d]   = resSetId;
            rTagN[t][d]  = resSetTag;
            rSlotN[t][d] = resSetSlot;
            placed = 1'b1;
          end
        end
      end
      resPend[t] = |rvN[t];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rv <= '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        for (int d = 0; d < RES_DEPTH; d++) begin
          rId[t][d]   <= '0;
          rTag[t][d]  <= '0;
          rSlot[t][d] <= '0;
        end
      end
    end else begin
      rv    <= rvN;
      rId   <= rIdN;
      rTag  <= rTagN;
      rSlot <= rSlotN;
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      evt[t].stalled = nxtStall[t] | resPend[t];
      evt[t].squash  = squashAny[t];
    end
  end

  // ---------------- assertions ----------------
  generate
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_sa
      if (s > STAGE_IDX && s <= LAST_STALL) begin : g_trk
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
          // R2
          unblock_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
            unblockIn[s][t] |=> !stallBits[s][t]);
          // R2
          stall_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
            (stallBits[s][t] && !unblockIn[s][t]) |=> stallBits[s][t]);
        end
      end
    end
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ra
      // R8
      one_removed_chk: assert property (@(posedge clk) disable iff (!rstN)
        (resClrValid && !resSetValid) |=> ($countones(rv[t]) + 1 >= $past($countones(rv[t]))));
      // R8
      set_no_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
        (resSetValid && !resClrValid) |=> ($countones(rv[t]) >= $past($countones(rv[t]))));
    end
  endgenerate

endmodule

// File: rtl/stc_thread_fsm.sv
module stc_thread_fsm
  import stc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter bit HAS_PREV    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  thrEvt_t                     evt [NUM_THREADS],
  input  logic [NUM_THREADS-1:0]      skidEmpty,
  output logic [NUM_THREADS-1:0][2:0] threadState,
  output logic [NUM_THREADS-1:0]      blockOut,
  output logic [NUM_THREADS-1:0]      unblockOut,
  output logic [NUM_THREADS-1:0]      activityOut,
  output logic                        stageActive,
  output logic                        activateEvt,
  output logic                        deactivateEvt
);

  thrState_e stateQ [NUM_THREADS];
  thrState_e midSt  [NUM_THREADS];
  thrState_e nextSt [NUM_THREADS];
  logic [NUM_THREADS-1:0] blkD, ublkD, actD, blkQ, ublkQ;
  logic anyUnblk;

  always_comb begin
    blkD     = '0;
    ublkD    = '0;
    actD     = '0;
    anyUnblk = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      midSt[t]  = evt[t].squash ? ST_SQUASH : stateQ[t];
      nextSt[t] = midSt[t];
      if (evt[t].stalled) begin
        nextSt[t] = ST_BLOCK;
        if (midSt[t] != ST_BLOCK) begin
          blkD[t] = 1'b1;
          actD[t] = (midSt[t] != ST_UNBLK);
        end
      end else begin
        case (midSt[t])
          ST_BLOCK, ST_UNBLK: begin
            nextSt[t] = skidEmpty[t] ? ST_RUN : ST_UNBLK;
            ublkD[t]  = skidEmpty[t];
            actD[t]   = skidEmpty[t];
          end
          ST_SQUASH: nextSt[t] = skidEmpty[t] ? ST_RUN : ST_UNBLK;
          default: ;
        endcase
      end
      anyUnblk = anyUnblk | (nextSt[t] == ST_UNBLK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_THREADS; t++) stateQ[t] <= ST_IDLE;
      blkQ          <= '0;
      ublkQ         <= '0;
      activityOut   <= '0;
      stageActive   <= 1'b0;
      activateEvt   <= 1'b0;
      deactivateEvt <= 1'b0;
    end else begin
      stateQ        <= nextSt;
      blkQ          <= blkD;
      ublkQ         <= ublkD;
      activityOut   <= actD;
      stageActive   <= anyUnblk;
      activateEvt   <= anyUnblk & ~stageActive;
      deactivateEvt <= ~anyUnblk & stageActive;
    end
  end

  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_out
      assign threadState[t] = stateQ[t];
    end
    if (HAS_PREV) begin : g_prev
      assign blockOut   = blkQ;
      assign unblockOut = ublkQ;
    end else begin : g_first
      assign blockOut   = '0;
      assign unblockOut = '0;
    end
  endgenerate

  // ---------------- assertions ----------------
  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_fa
      // R5
      block_state_chk: assert property (@(posedge clk) disable iff (!rstN)
        blockOut[t] |-> (threadState[t] == ST_BLOCK));
      // R6
      unblock_state_chk: assert property (@(posedge clk) disable iff (!rstN)
        unblockOut[t] |-> (threadState[t] == ST_RUN));
      // R4
      no_squash_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        threadState[t] != ST_SQUASH);
    end
  endgenerate

  // R10
  activate_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    activateEvt |-> (stageActive && !$past(stageActive)));
  // R10
  deactivate_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    deactivateEvt |-> (!stageActive && $past(stageActive)));
  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({activateEvt, deactivateEvt}));

endmodule

// File: rtl/stage_thread_ctrl.sv
module stage_thread_ctrl
  import stc_pkg::*;
#(
  parameter int NUM_STAGES  = 4,
  parameter int NUM_THREADS = 2,
  parameter int STAGE_IDX   = 1,
  parameter int LAST_STALL  = NUM_STAGES - 1,
  parameter int SEQ_W       = 8,
  parameter int RES_ID_W    = 3,
  parameter int TAG_W       = 6,
  parameter int SLOT_W      = 2,
  parameter int RES_DEPTH   = 4,
  localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                                              clk,
  input  logic                                              rstN,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0]            blockIn,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0]            unblockIn,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0]            squashIn,
  input  logic [NUM_STAGES-1:0][NUM_THREADS-1:0][SEQ_W-1:0] squashSeqIn,
  input  logic [NUM_THREADS-1:0]                            skidEmpty,
  input  logic                                              resSetValid,
  input  logic [THR_W-1:0]                                  resSetThread,
  input  logic [RES_ID_W-1:0]                               resSetId,
  input  logic [TAG_W-1:0]                                  resSetTag,
  input  logic [SLOT_W-1:0]                                 resSetSlot,
  input  logic                                              resClrValid,
  input  logic [THR_W-1:0]                                  resClrThread,
  input  logic [RES_ID_W-1:0]                               resClrId,
  input  logic [TAG_W-1:0]                                  resClrTag,
  input  logic [SLOT_W-1:0]                                 resClrSlot,
  output logic [NUM_THREADS-1:0][2:0]                       threadState,
  output logic [NUM_THREADS-1:0]                            blockOut,
  output logic [NUM_THREADS-1:0]                            unblockOut,
  output logic [NUM_THREADS-1:0]                            activityOut,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]                 squashSeqOut,
  output logic                                              stageActive,
  output logic                                              activateEvt,
  output logic                                              deactivateEvt
);

  thrEvt_t evt [NUM_THREADS];

  stc_signal_path #(
    .NUM_STAGES(NUM_STAGES), .NUM_THREADS(NUM_THREADS), .STAGE_IDX(STAGE_IDX),
    .LAST_STALL(LAST_STALL), .SEQ_W(SEQ_W), .RES_ID_W(RES_ID_W), .TAG_W(TAG_W),
    .SLOT_W(SLOT_W), .RES_DEPTH(RES_DEPTH)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .blockIn(blockIn), .unblockIn(unblockIn), .squashIn(squashIn), .squashSeqIn(squashSeqIn),
    .resSetValid(resSetValid), .resSetThread(resSetThread), .resSetId(resSetId),
    .resSetTag(resSetTag), .resSetSlot(resSetSlot),
    .resClrValid(resClrValid), .resClrThread(resClrThread), .resClrId(resClrId),
    .resClrTag(resClrTag), .resClrSlot(resClrSlot),
    .evt(evt), .squashSeqOut(squashSeqOut)
  );

  stc_thread_fsm #(
    .NUM_THREADS(NUM_THREADS), .HAS_PREV(STAGE_IDX > 0)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .evt(evt), .skidEmpty(skidEmpty),
    .threadState(threadState), .blockOut(blockOut), .unblockOut(unblockOut),
    .activityOut(activityOut), .stageActive(stageActive),
    .activateEvt(activateEvt), .deactivateEvt(deactivateEvt)
  );

endmodule

// File: tb/stage_thread_ctrl_bench.sv
module stage_thread_ctrl_bench;

  localparam int S = 4, T = 2, SQW = 8, IDW = 3, TGW = 6, SLW = 2, DEP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [S-1:0][T-1:0] blockIn, unblockIn, squashIn;
  logic [S-1:0][T-1:0][SQW-1:0] squashSeqIn;
  logic [T-1:0] skidEmpty;
  logic resSetValid, resClrValid;
  logic [0:0] resSetThread, resClrThread;
  logic [IDW-1:0] resSetId, resClrId;
  logic [TGW-1:0] resSetTag, resClrTag;
  logic [SLW-1:0] resSetSlot, resClrSlot;

  logic [T-1:0][2:0] threadState, fState;
  logic [T-1:0] blockOut, unblockOut, activityOut, fBlock, fUnblock, fAct;
  logic [T-1:0][SQW-1:0] squashSeqOut, fSeq;
  logic stageActive, activateEvt, deactivateEvt, fActive, fActEvt, fDeactEvt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stage_thread_ctrl #(.STAGE_IDX(1)) u_stage_thread_ctrl (
    .clk(clk), .rstN(rstN), .blockIn(blockIn), .unblockIn(unblockIn), .squashIn(squashIn),
    .squashSeqIn(squashSeqIn), .skidEmpty(skidEmpty),
    .resSetValid(resSetValid), .resSetThread(resSetThread), .resSetId(resSetId),
    .resSetTag(resSetTag), .resSetSlot(resSetSlot),
    .resClrValid(resClrValid), .resClrThread(resClrThread), .resClrId(resClrId),
    .resClrTag(resClrTag), .resClrSlot(resClrSlot),
    .threadState(threadState), .blockOut(blockOut), .unblockOut(unblockOut),
    .activityOut(activityOut), .squashSeqOut(squashSeqOut), .stageActive(stageActive),
    .activateEvt(activateEvt), .deactivateEvt(deactivateEvt));

  stage_thread_ctrl #(.STAGE_IDX(0)) u_stage_thread_ctrl_first (
    .clk(clk), .rstN(rstN), .blockIn(blockIn), .unblockIn(unblockIn), .squashIn(squashIn),
    .squashSeqIn(squashSeqIn), .skidEmpty(skidEmpty),
    .resSetValid(resSetValid), .resSetThread(resSetThread), .resSetId(resSetId),
    .resSetTag(resSetTag), .resSetSlot(resSetSlot),
    .resClrValid(resClrValid), .resClrThread(resClrThread), .resClrId(resClrId),
    .resClrTag(resClrTag), .resClrSlot(resClrSlot),
    .threadState(fState), .blockOut(fBlock), .unblockOut(fUnblock),
    .activityOut(fAct), .squashSeqOut(fSeq), .stageActive(fActive),
    .activateEvt(fActEvt), .deactivateEvt(fDeactEvt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleIn();
    blockIn = '0; unblockIn = '0; squashIn = '0; squashSeqIn = '0; skidEmpty = '1;
    resSetValid = 1'b0; resSetThread = '0; resSetId = '0; resSetTag = '0; resSetSlot = '0;
    resClrValid = 1'b0; resClrThread = '0; resClrId = '0; resClrTag = '0; resClrSlot = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    idleIn();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    rstN = 1'b1;
  endtask

  // Reach a start state on thread t through the ports: 0 Idle, 1 Running, 2 Blocked, 3 Unblocking.
  task automatic goState(input int t, input int st);
    if (st == 0) return;
    blockIn[2][t] = 1'b1;
    step();
    idleIn();
    if (st == 2) return;
    unblockIn[2][t] = 1'b1;
    skidEmpty[t] = (st == 1);
    step();
    idleIn();
  endtask

  task automatic setRes(input int t, input int id, input int tag, input int slot);
    resSetValid = 1'b1; resSetThread = 1'(t); resSetId = IDW'(id);
    resSetTag = TGW'(tag); resSetSlot = SLW'(slot);
  endtask

  task automatic clrRes(input int t, input int id, input int tag, input int slot);
    resClrValid = 1'b1; resClrThread = 1'(t); resClrId = IDW'(id);
    resClrTag = TGW'(tag); resClrSlot = SLW'(slot);
  endtask

  // Expected next state and pulses for one cycle, from the requirements.
  function automatic void model(input int cur, input bit stall, input bit sq, input bit skid,
                                output int nxt, output bit blk, output bit ub, output bit act);
    int mid;
    mid = sq ? 4 : cur;
    blk = 1'b0; ub = 1'b0; act = 1'b0;
    if (stall) begin
      nxt = 2;
      if (mid != 2) begin blk = 1'b1; act = (mid != 3); end
    end else if (mid == 2 || mid == 3) begin
      nxt = skid ? 1 : 3; ub = skid; act = skid;
    end else if (mid == 4) begin
      nxt = skid ? 1 : 3;
    end else begin
      nxt = mid;
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    for (int t = 0; t < T; t++) begin
      chk("R1 state", int'(threadState[t]), 0);
      chk("R1 blockOut", int'(blockOut[t]), 0);
      chk("R1 unblockOut", int'(unblockOut[t]), 0);
      chk("R1 activity", int'(activityOut[t]), 0);
      chk("R1 seq", int'(squashSeqOut[t]), 0);
    end
    chk("R1 stageActive", int'(stageActive), 0);

    // Sweep: start state x stall x squash x skid, both threads (R4 R5 R6 R7 R10 R12)
    for (int t = 0; t < T; t++) begin
      for (int st = 0; st < 4; st++) begin
        for (int c = 0; c < 8; c++) begin
          int nxt; bit blk, ub, act, stl, sq, sk;
          stl = c[0]; sq = c[1]; sk = c[2];
          doReset();
          goState(t, st);
          if (stl) blockIn[2][t] = 1'b1; else unblockIn[2][t] = 1'b1;
          if (sq) begin squashIn[2][t] = 1'b1; squashSeqIn[2][t] = SQW'(8'hA0 + c); end
          skidEmpty[t] = sk;
          step();
          model(st, stl, sq, sk, nxt, blk, ub, act);
          chk("R5/R6/R7 state", int'(threadState[t]), nxt);
          chk("R5 blockOut", int'(blockOut[t]), int'(blk));
          chk("R6/R7 unblockOut", int'(unblockOut[t]), int'(ub));
          chk("R5/R6 activity", int'(activityOut[t]), int'(act));
          chk("R4 seq", int'(squashSeqOut[t]), sq ? (8'hA0 + c) : 0);
          chk("R10 stageActive", int'(stageActive), int'(nxt == 3));
          chk("R10 activateEvt", int'(activateEvt), int'(nxt == 3 && st != 3));
          chk("R10 deactivateEvt", int'(deactivateEvt), int'(nxt != 3 && st == 3));
          chk("R12 other thread", int'(threadState[1-t]), 0);
          idleIn();
        end
      end
    end

    // R2 sticky bit, no repeated pulse
    doReset();
    blockIn[2][0] = 1'b1; step(); idleIn();
    chk("R2 block sets", int'(threadState[0]), 2);
    chk("R5 first pulse", int'(blockOut[0]), 1);
    step();
    chk("R2 sticky", int'(threadState[0]), 2);
    chk("R5 no repeat pulse", int'(blockOut[0]), 0);
    unblockIn[2][0] = 1'b1; step(); idleIn();
    chk("R2 release", int'(threadState[0]), 1);
    chk("R6 unblock pulse", int'(unblockOut[0]), 1);

    // R2 unblock wins over block in the same cycle
    blockIn[2][0] = 1'b1; unblockIn[2][0] = 1'b1; step(); idleIn();
    chk("R2 unblock wins", int'(threadState[0]), 1);
    step();
    chk("R2 bit stays clear", int'(threadState[0]), 1);

    // R3 ignored stages
    blockIn[3][0] = 1'b1; step(); idleIn();
    chk("R3 later stage no stall", int'(threadState[0]), 1);
    unblockIn[3][0] = 1'b1; step(); idleIn();
    blockIn[0][0] = 1'b1; step(); idleIn();
    chk("R3 earlier block ignored", int'(threadState[0]), 1);
    chk("R3 earlier block no pulse", int'(blockOut[0]), 0);
    squashIn[0][0] = 1'b1; squashSeqIn[0][0] = 8'h55; skidEmpty[0] = 1'b0; step(); idleIn();
    chk("R3 earlier squash state", int'(threadState[0]), 1);
    chk("R3 earlier squash seq", int'(squashSeqOut[0]), 0);

    // R4 lowest stage index wins
    squashIn[1][0] = 1'b1; squashSeqIn[1][0] = 8'h11;
    squashIn[3][0] = 1'b1; squashSeqIn[3][0] = 8'h33; step(); idleIn();
    chk("R4 own stage lowest", int'(squashSeqOut[0]), 8'h11);
    squashIn[2][0] = 1'b1; squashSeqIn[2][0] = 8'h22;
    squashIn[3][0] = 1'b1; squashSeqIn[3][0] = 8'h33; step(); idleIn();
    chk("R4 stage 2 over 3", int'(squashSeqOut[0]), 8'h22);
    chk("R4 other thread seq", int'(squashSeqOut[1]), 0);

    // R8 resource stall matching
    setRes(0, 2, 5, 1); step(); idleIn();
    chk("R8 set stalls", int'(threadState[0]), 2);
    chk("R12 set same cycle", int'(blockOut[0]), 1);
    clrRes(0, 2, 6, 1); step(); idleIn();
    chk("R8 tag mismatch", int'(threadState[0]), 2);
    clrRes(0, 2, 5, 2); step(); idleIn();
    chk("R8 slot mismatch", int'(threadState[0]), 2);
    clrRes(0, 3, 5, 1); step(); idleIn();
    chk("R8 id mismatch", int'(threadState[0]), 2);
    clrRes(1, 2, 5, 1); step(); idleIn();
    chk("R8 thread mismatch", int'(threadState[0]), 2);
    chk("R8 other thread idle", int'(threadState[1]), 0);
    clrRes(0, 2, 5, 1); step(); idleIn();
    chk("R8 match releases", int'(threadState[0]), 1);
    chk("R8 unblock pulse", int'(unblockOut[0]), 1);

    // R8 duplicates each need a clear
    setRes(0, 1, 9, 0); step(); idleIn();
    setRes(0, 1, 9, 0); step(); idleIn();
    clrRes(0, 1, 9, 0); step(); idleIn();
    chk("R8 duplicate still stalled", int'(threadState[0]), 2);
    clrRes(0, 1, 9, 0); step(); idleIn();
    chk("R8 second clear releases", int'(threadState[0]), 1);

    // R9 full table drops the extra set
    for (int k = 0; k < DEP + 1; k++) begin
      setRes(0, 4, k, 3); step(); idleIn();
    end
    for (int k = 0; k < DEP; k++) begin
      clrRes(0, 4, k, 3); step(); idleIn();
    end
    chk("R9 extra set dropped", int'(threadState[0]), 1);
    clrRes(0, 4, DEP, 3); step(); idleIn();
    chk("R9 clear of dropped entry", int'(threadState[0]), 1);
    chk("R9 no block pulse", int'(blockOut[0]), 0);

    // R11 first-stage instance never signals backward
    doReset();
    blockIn[1][0] = 1'b1; step(); idleIn();
    chk("R11 first stage blocked", int'(fState[0]), 2);
    chk("R11 no blockOut", int'(fBlock[0]), 0);
    chk("R11 activity still", int'(fAct[0]), 1);
    unblockIn[1][0] = 1'b1; step(); idleIn();
    chk("R11 first stage running", int'(fState[0]), 1);
    chk("R11 no unblockOut", int'(fUnblock[0]), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule